// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers up to 22 pending-interrupt flags and decides when a small 8-bit CPU core is to be interrupted. A flag is set by a hardware event pulse or by a software set strobe, whether or not the source is enabled. The flag is cleared by a software clear strobe. For sources marked in a parameter, the flag is also cleared automatically when the CPU takes the vector. A source can raise a request only if its pending flag is set, its enable bit is set and the global enable is set. Each source carries a priority bit that places it in the high or the low level.

The CPU reports each instruction boundary, each accepted vector and each completed return-from-interrupt. At a boundary the controller picks the winning source and presents a registered request together with a 16-bit vector address. It keeps one in-service bit per level. Those bits decide preemption: a high request may interrupt a low routine, and nothing interrupts a high routine. After a return, one further instruction always runs before any new entry is made.

Top module: `vic2_ctrl`

## Requirements
- R1: A pending flag is set on the edge after its `src_evt` or `sw_set` bit is high, regardless of `en_mask`, `glb_en` or any clear in the same cycle. Setting takes precedence over clearing.
- R2: A `sw_clr` bit clears its pending flag on the next edge, unless R1 sets the flag in the same cycle.
- R3: A source is eligible only when its pending flag, its `en_mask` bit and `glb_en` are all 1. With `glb_en` at 0, no request is raised whatever `en_mask` holds.
- R4: `irq_req` rises only on the edge where `insn_done` is high. It then carries `irq_src` set to the winning index and `irq_vec` equal to 0x0003 + 8 × index.
- R5: Any eligible high-priority source (`hi_prio` bit 1) beats every low one. Within a level, the lowest index wins.
- R6: `vec_ack` while `irq_req` is high does three things on that edge. It drops `irq_req`. It sets the in-service bit of the request's level (`in_service[1]` for high, `in_service[0]` for low). If the source's bit in AUTO_CLR is 1, it also clears that source's pending flag.
- R7: A high request is issued only while `in_service[1]` is 0. A low request is issued only while both in-service bits are 0.
- R8: `ret_done` clears `in_service[1]` if it is set, and otherwise clears `in_service[0]`.
- R9: After `ret_done`, the first `insn_done` issues no request. A flag that is still eligible is taken at the second `insn_done`.
- R10: While `irq_req` is high, `irq_src` and `irq_vec` hold steady until `vec_ack`. No new winner is captured during that time.
- R11: Reset clears all pending flags, `irq_req` and both in-service bits.
- R12: `vec_ack` while `irq_req` is low changes neither the in-service bits nor the pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | N_SRC | Hardware event pulses, one per source |
| sw_set | input | N_SRC | Software set strobes for the pending flags |
| sw_clr | input | N_SRC | Software clear strobes for the pending flags |
| en_mask | input | N_SRC | Per-source enable |
| hi_prio | input | N_SRC | Per-source level, 1 = high |
| glb_en | input | 1 | Global enable |
| insn_done | input | 1 | Instruction boundary strobe |
| vec_ack | input | 1 | CPU has taken the presented vector |
| ret_done | input | 1 | Return-from-interrupt completed |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 16 | Vector address of the request |
| irq_src | output | IDXW | Index of the requesting source |
| pend_flags | output | N_SRC | Pending flags |
| in_service | output | 2 | In-service bits: [1] high level, [0] low level |

## Verification
The assertions assume a well-behaved CPU. `vec_ack` and `ret_done` never arrive on the same edge. `ret_done` comes only while an in-service bit is set. `hi_prio` changes only when no request is being captured. The stimulus keeps to this: every strobe is a single-cycle pulse driven at the falling edge, the level and enable registers change only between scenarios, and each return follows an acknowledged entry. A reference model in the bench recomputes flags, request, vector and in-service state on every clock.

// File: rtl/vic2_pkg.sv
package vic2_pkg;
    localparam int          VEC_W     = 16;
    localparam logic [15:0] VEC_BASE  = 16'h0003;
    localparam int          VEC_SHIFT = 3;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;
endpackage

// File: rtl/vic2_pend.sv
module vic2_pend #(
    parameter int          N        = 22,
    parameter logic [N-1:0] AUTO_CLR = '0,
    parameter int          IDXW     = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    evt,
    input  logic [N-1:0]    set,
    input  logic [N-1:0]    clr,
    input  logic            take,
    input  logic [IDXW-1:0] take_src,
    output logic [N-1:0]    pend_q
);
    logic [N-1:0] auto_hit;
    logic [N-1:0] pend_d;

    for (genvar i = 0; i < N; i++) begin : g_auto
        if (AUTO_CLR[i]) begin : g_on
            assign auto_hit[i] = take && (take_src == IDXW'(i));
        end else begin : g_off
            assign auto_hit[i] = 1'b0;
        end
    end

    always_comb begin
        pend_d = (pend_q & ~clr & ~auto_hit) | evt | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/vic2_pick.sv
module vic2_pick #(
    parameter int N    = 22,
    parameter int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    elig,
    input  logic [N-1:0]    hi_prio,
    input  logic            ins_hi,
    input  logic            ins_lo,
    output logic            valid,
    output logic            sel_hi,
    output logic [IDXW-1:0] sel
);
    logic            hi_any, lo_any;
    logic [IDXW-1:0] hi_idx, lo_idx;

    always_comb begin
        hi_any = 1'b0;
        lo_any = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i] && hi_prio[i]) begin
                hi_any = 1'b1;
                hi_idx = IDXW'(i);
            end
            if (elig[i] && !hi_prio[i]) begin
                lo_any = 1'b1;
                lo_idx = IDXW'(i);
            end
        end
        sel_hi = hi_any && !ins_hi;
        valid  = !ins_hi && (hi_any || (lo_any && !ins_lo));
        sel    = hi_any ? hi_idx : lo_idx;
    end
endmodule

// File: rtl/vic2_seq.sv
module vic2_seq #(
    parameter int N    = 22,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_done,
    input  logic            vec_ack,
    input  logic            ret_done,
    input  logic            pick_valid,
    input  logic            pick_hi,
    input  logic [IDXW-1:0] pick_sel,
    output logic            req,
    output logic [IDXW-1:0] src,
    output logic            ins_hi,
    output logic            ins_lo,
    output logic            take
);
    import vic2_pkg::*;

    typedef struct packed {
        logic            req;
        lvl_e            lvl;
        logic [IDXW-1:0] src;
        logic            ins_hi;
        logic            ins_lo;
        logic            hold;
    } seq_t;

    seq_t st_d, st_q;
    logic ack_ok, capture;

    always_comb begin
        st_d    = st_q;
        ack_ok  = st_q.req && vec_ack;
        capture = insn_done && !st_q.req && !ret_done && !st_q.hold && pick_valid;

        if (ret_done) begin
            if (st_q.ins_hi) st_d.ins_hi = 1'b0;
            else             st_d.ins_lo = 1'b0;
            st_d.hold = 1'b1;
        end else if (insn_done && st_q.hold) begin
            st_d.hold = 1'b0;
        end

        if (ack_ok) begin
            st_d.req = 1'b0;
            if (st_q.lvl == LVL_HI) st_d.ins_hi = 1'b1;
            else                    st_d.ins_lo = 1'b1;
        end

        if (capture) begin
            st_d.req = 1'b1;
            st_d.src = pick_sel;
            st_d.lvl = pick_hi ? LVL_HI : LVL_LO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{req: 1'b0, lvl: LVL_LO, src: '0,
                      ins_hi: 1'b0, ins_lo: 1'b0, hold: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req    = st_q.req;
    assign src    = st_q.src;
    assign ins_hi = st_q.ins_hi;
    assign ins_lo = st_q.ins_lo;
    assign take   = ack_ok;
endmodule

// File: rtl/vic2_ctrl.sv
module vic2_ctrl #(
    parameter int           N_SRC    = 22,
    parameter logic [N_SRC-1:0] AUTO_CLR = N_SRC'(3),
    parameter int           IDXW     = $clog2(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_evt,
    input  logic [N_SRC-1:0]        sw_set,
    input  logic [N_SRC-1:0]        sw_clr,
    input  logic [N_SRC-1:0]        en_mask,
    input  logic [N_SRC-1:0]        hi_prio,
    input  logic                    glb_en,
    input  logic                    insn_done,
    input  logic                    vec_ack,
    input  logic                    ret_done,
    output logic                    irq_req,
    output logic [vic2_pkg::VEC_W-1:0] irq_vec,
    output logic [IDXW-1:0]         irq_src,
    output logic [N_SRC-1:0]        pend_flags,
    output logic [1:0]              in_service
);
    import vic2_pkg::*;

    logic [N_SRC-1:0] elig;
    logic             pick_valid, pick_hi, take, ins_hi, ins_lo;
    logic [IDXW-1:0]  pick_sel;

    vic2_pend #(.N(N_SRC), .AUTO_CLR(AUTO_CLR), .IDXW(IDXW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (src_evt),
        .set      (sw_set),
        .clr      (sw_clr),
        .take     (take),
        .take_src (irq_src),
        .pend_q   (pend_flags)
    );

    assign elig = pend_flags & en_mask & {N_SRC{glb_en}};

    vic2_pick #(.N(N_SRC), .IDXW(IDXW)) u_pick (
        .elig    (elig),
        .hi_prio (hi_prio),
        .ins_hi  (ins_hi),
        .ins_lo  (ins_lo),
        .valid   (pick_valid),
        .sel_hi  (pick_hi),
        .sel     (pick_sel)
    );

    vic2_seq #(.N(N_SRC), .IDXW(IDXW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_done  (insn_done),
        .vec_ack    (vec_ack),
        .ret_done   (ret_done),
        .pick_valid (pick_valid),
        .pick_hi    (pick_hi),
        .pick_sel   (pick_sel),
        .req        (irq_req),
        .src        (irq_src),
        .ins_hi     (ins_hi),
        .ins_lo     (ins_lo),
        .take       (take)
    );

    assign in_service = {ins_hi, ins_lo};
    assign irq_vec    = VEC_BASE + (VEC_W'(irq_src) << VEC_SHIFT);
endmodule

// File: rtl/vic2_chk.sv
module vic2_chk #(
    parameter int N_SRC = 22,
    parameter int IDXW  = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_evt,
    input logic [N_SRC-1:0] sw_set,
    input logic [N_SRC-1:0] hi_prio,
    input logic             glb_en,
    input logic             insn_done,
    input logic             vec_ack,
    input logic             ret_done,
    input logic             irq_req,
    input logic [15:0]      irq_vec,
    input logic [IDXW-1:0]  irq_src,
    input logic [N_SRC-1:0] pend_flags,
    input logic [1:0]       in_service
);
    logic [N_SRC-1:0] hp_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hp_prev <= '0;
        else        hp_prev <= hi_prio;
    end

    assert_pend_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_evt | sw_set) != '0) |=> ((pend_flags & $past(src_evt | sw_set)) == $past(src_evt | sw_set)));

    assert_glb_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(glb_en));

    assert_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(insn_done));

    assert_ack_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && vec_ack && !ret_done) |=> (!irq_req && $countones(in_service) >= 1));

    assert_no_hi_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> !$past(in_service[1]));

    assert_lo_by_hi_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req) && $past(in_service[0])) |-> hp_prev[irq_src]);

    assert_ret_hi_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done && !vec_ack && in_service[1]) |=> (!in_service[1] && in_service[0] == $past(in_service[0])));

    assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !vec_ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_src)));

    assert_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && vec_ack && !ret_done) |=> (in_service == $past(in_service)));
endmodule

bind vic2_ctrl vic2_chk #(.N_SRC(N_SRC), .IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_evt    (src_evt),
    .sw_set     (sw_set),
    .hi_prio    (hi_prio),
    .glb_en     (glb_en),
    .insn_done  (insn_done),
    .vec_ack    (vec_ack),
    .ret_done   (ret_done),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .irq_src    (irq_src),
    .pend_flags (pend_flags),
    .in_service (in_service)
);

// File: tb/sim_vic2_ctrl.sv
`timescale 1ns/1ps
module sim_vic2_ctrl;
    localparam int N = 22;
    localparam int W = $clog2(N);
    localparam logic [N-1:0] AUTO = N'(3);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_evt = '0, sw_set = '0, sw_clr = '0, en_mask = '0, hi_prio = '0;
    logic glb_en = 1'b0, insn_done = 1'b0, vec_ack = 1'b0, ret_done = 1'b0;
    logic irq_req;
    logic [15:0] irq_vec;
    logic [W-1:0] irq_src;
    logic [N-1:0] pend_flags;
    logic [1:0] in_service;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vic2_ctrl #(.N_SRC(N), .AUTO_CLR(AUTO)) u0 (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .sw_set(sw_set), .sw_clr(sw_clr),
        .en_mask(en_mask), .hi_prio(hi_prio), .glb_en(glb_en), .insn_done(insn_done),
        .vec_ack(vec_ack), .ret_done(ret_done), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_src(irq_src), .pend_flags(pend_flags), .in_service(in_service)
    );

    // behavioural reference model
    bit [N-1:0] m_pend;
    bit m_req, m_hi, m_ih, m_il, m_hold;
    int m_src;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = '0; m_req = 0; m_hi = 0; m_ih = 0; m_il = 0; m_hold = 0; m_src = 0;
        end else begin
            int w;
            bit wh, n_req, n_ih, n_il, n_hold;
            bit [N-1:0] np;
            w = -1; wh = 0;
            np = m_pend; n_req = m_req; n_ih = m_ih; n_il = m_il; n_hold = m_hold;
            if (insn_done && !m_req && !ret_done && !m_hold && glb_en && !m_ih) begin
                for (int i = 0; i < N; i++)
                    if (w < 0 && m_pend[i] && en_mask[i] && hi_prio[i]) begin w = i; wh = 1; end
                if (w < 0 && !m_il)
                    for (int i = 0; i < N; i++)
                        if (w < 0 && m_pend[i] && en_mask[i] && !hi_prio[i]) w = i;
            end
            if (m_req && vec_ack && AUTO[m_src]) np[m_src] = 1'b0;
            np = (np & ~sw_clr) | src_evt | sw_set;
            if (ret_done) begin
                if (m_ih) n_ih = 0; else n_il = 0;
                n_hold = 1;
            end else if (insn_done && m_hold) n_hold = 0;
            if (m_req && vec_ack) begin
                n_req = 0;
                if (m_hi) n_ih = 1; else n_il = 1;
            end
            if (w >= 0) begin n_req = 1; m_src = w; m_hi = wh; end
            m_pend = np; m_req = n_req; m_ih = n_ih; m_il = n_il; m_hold = n_hold;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(pend_flags == m_pend, "R1 model pending", pend_flags, m_pend);
            check(irq_req == m_req, "R4 model request", irq_req, m_req);
            if (m_req) begin
                check(int'(irq_src) == m_src, "R5 model source", irq_src, m_src);
                check(int'(irq_vec) == 3 + 8 * m_src, "R4 model vector", irq_vec, 3 + 8 * m_src);
            end
            check(in_service == {m_ih, m_il}, "R6 model in-service", in_service, {m_ih, m_il});
        end
    end

    task automatic cyc(input logic [N-1:0] e, input logic [N-1:0] s, input logic [N-1:0] c,
                       input logic id, input logic ak, input logic rt);
        src_evt = e; sw_set = s; sw_clr = c; insn_done = id; vec_ack = ak; ret_done = rt;
        @(negedge clk);
        src_evt = '0; sw_set = '0; sw_clr = '0; insn_done = 0; vec_ack = 0; ret_done = 0;
    endtask

    function automatic logic [N-1:0] b(input int i);
        return N'(1) << i;
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pend_flags == 0 && !irq_req && in_service == 0, "R11 reset state", {pend_flags, irq_req, in_service}, 0);

        cyc(b(5), 0, 0, 0, 0, 0);
        check(pend_flags[5], "R1 masked flag latches", pend_flags, b(5));
        cyc(0, 0, 0, 1, 0, 0);
        check(!irq_req, "R3 disabled source no request", irq_req, 0);
        en_mask = b(5) | b(2);
        cyc(0, 0, 0, 1, 0, 0);
        check(!irq_req, "R3 global enable off blocks", irq_req, 0);
        glb_en = 1;
        cyc(0, 0, 0, 0, 0, 0);
        check(!irq_req, "R4 no request without boundary", irq_req, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(irq_req && irq_vec == 16'h002B && irq_src == 5, "R4 vector for source 5", irq_vec, 16'h002B);
        cyc(b(2), 0, 0, 1, 0, 0);
        check(irq_req && irq_src == 5, "R10 request holds vector", irq_src, 5);
        cyc(0, 0, 0, 0, 1, 0);
        check(!irq_req && in_service == 2'b01 && pend_flags[5], "R6 ack sets low level, no auto clear", {in_service, pend_flags[5]}, 3'b011);
        cyc(0, 0, 0, 1, 0, 0);
        check(!irq_req, "R7 low does not preempt low", irq_req, 0);
        cyc(0, 0, b(2), 0, 0, 0);
        check(!pend_flags[2], "R2 software clear", pend_flags, 0);
        cyc(0, 0, 0, 0, 0, 1);
        check(in_service == 0, "R8 return clears low", in_service, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(!irq_req, "R9 one instruction after return", irq_req, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(irq_req && irq_src == 5, "R9 re-entry of still-set flag", irq_src, 5);
        cyc(0, 0, 0, 0, 1, 0);

        hi_prio = b(9) | b(11);
        en_mask = en_mask | b(9) | b(11);
        cyc(0, b(9), 0, 0, 0, 0);
        check(pend_flags[9], "R1 software set", pend_flags, b(9) | b(5));
        cyc(0, 0, 0, 1, 0, 0);
        check(irq_req && irq_vec == 16'h004B, "R7 high preempts low", irq_vec, 16'h004B);
        cyc(0, 0, 0, 0, 1, 0);
        check(in_service == 2'b11, "R6 ack sets high level", in_service, 2'b11);
        cyc(b(11), 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(!irq_req, "R7 nothing preempts high", irq_req, 0);
        cyc(0, 0, 0, 0, 0, 1);
        check(in_service == 2'b01, "R8 return clears high first", in_service, 2'b01);
        cyc(0, 0, b(5) | b(9) | b(11), 0, 0, 0);
        check(pend_flags == 0, "R2 clear several flags", pend_flags, 0);
        cyc(0, 0, 0, 0, 0, 1);
        check(in_service == 0, "R8 second return", in_service, 0);
        cyc(0, 0, 0, 0, 1, 0);
        check(in_service == 0 && !irq_req && pend_flags == 0, "R12 stray ack ignored", in_service, 0);

        en_mask = en_mask | b(3) | b(7) | b(4) | b(0);
        cyc(0, b(3) | b(7), 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(irq_req && irq_src == 3, "R5 lowest index in level", irq_src, 3);
        cyc(0, 0, b(3), 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        hi_prio = hi_prio | b(7);
        cyc(b(4), 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(irq_req && irq_src == 7, "R5 high beats lower-index low", irq_src, 7);
        cyc(0, 0, b(7), 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(irq_req && irq_src == 4, "R5 remaining low taken", irq_src, 4);
        cyc(0, 0, b(4), 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);

        cyc(b(0), 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(irq_req && irq_vec == 16'h0003, "R4 vector for source 0", irq_vec, 16'h0003);
        cyc(0, 0, 0, 0, 1, 0);
        check(!pend_flags[0], "R6 auto clear on ack", pend_flags, 0);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, b(12), b(12), 0, 0, 0);
        check(pend_flags[12], "R1 set wins over clear", pend_flags, b(12));
        cyc(0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule